// File: doc/BRIEF.md
# Shared-Resource Vector Magnitude Estimator

This block estimates the length of a two-dimensional vector, sqrt(a² + b²), from two signed components. It does so without a multiplier or a root extractor. The estimate is max(x − x/8 + y/2, x), where x is the larger and y is the smaller of the two absolute values. The block is a multi-cycle controller-plus-datapath design:

- three working registers are reused for every intermediate value;
- two multi-function arithmetic units carry all the arithmetic;
- two fixed right shifters produce the scaled terms.

Each working register holds values whose lifetimes do not overlap. Each unit performs at most one operation per controller state.

A client raises `start` for one cycle while the block is idle, with `in_a` and `in_b` valid in that cycle. Seven cycles later `done` pulses, and `mag` carries the estimate. `mag` keeps that value until the next accepted start.

Top module: `sra_magnitude`

## Requirements
- R1: A clock edge with `rst_n` low puts the block in idle, with `done` = 0 and `mag` = 0.
- R2: When `start` is sampled high in idle, `done` is high in the cycle that follows the seventh rising edge. The edge that sampled `start` counts as the first.
- R3: `done` is never high for two consecutive cycles.
- R4: When `done` is high, `mag` equals max(x − (x>>3) + (y>>1), x).
  - x = max(|a|,|b|) and y = min(|a|,|b|).
  - Both shifts are logical and truncate toward zero.
- R5: The absolute value of the most negative input, −2^(W−1), is taken as 2^(W−1)−1.
- R6: `start` is ignored in every cycle in which the block is not idle, including the `done` cycle. A `start` held high therefore begins a new computation every eight cycles.
- R7: `mag` stays unchanged from the `done` cycle until the edge that accepts the next start.
- R8: Swapping `in_a` and `in_b` gives the same `mag`.
- R9: The result is never smaller than max(|a|,|b|).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a computation (taken only in idle) |
| in_a | input | W | First component, two's complement |
| in_b | input | W | Second component, two's complement |
| mag | output | W | Unsigned magnitude estimate |
| done | output | 1 | One-cycle pulse, `mag` valid |

## Verification
The bench drives the corner cases a shared-register schedule is likely to get wrong:

- **Most negative input.** A design without saturation would produce a negative absolute value, and with it a wildly wrong result.
- **Inputs in either order, and inputs where the max term wins.** A swapped min/max or a dropped final max would give an asymmetric or undersized result.
- **`start` held high through a whole run.** A controller that re-accepts mid-run would restart, corrupt a shared register and shift the `done` pulse.
- **Zero inputs and full-scale inputs.** These expose overflow in the add and truncation mistakes in the shifters.

// File: rtl/sra_pkg.sv
// Package: state encoding, unit opcodes and the control word shared by the
// controller and the datapath of the magnitude estimator.
package sra_pkg;

    // Controller states, one per schedule step.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ABS,
        ST_ORDER,
        ST_SCALE,
        ST_TRIM,
        ST_SUM,
        ST_PICK,
        ST_DONE
    } sra_state_e;

    // Operations of the four-function unit.
    typedef enum logic [1:0] {
        AU1_ABS,
        AU1_MIN,
        AU1_ADD,
        AU1_SUB
    } au1_op_e;

    // Operations of the two-function unit.
    typedef enum logic {
        AU2_ABS,
        AU2_MAX
    } au2_op_e;

    // First-operand source for the four-function unit.
    typedef enum logic [1:0] {
        SRC_R1,
        SRC_R2,
        SRC_R3
    } au1_src_e;

    // Write selects of the working registers.
    typedef enum logic [1:0] {
        R1_KEEP,
        R1_INPUT,
        R1_FROM_AU2
    } r1_sel_e;

    typedef enum logic [1:0] {
        R2_KEEP,
        R2_INPUT,
        R2_FROM_AU1,
        R2_FROM_SH
    } r2_sel_e;

    // Control word issued by the controller in each state.
    typedef struct packed {
        au1_op_e  au1_op;
        au1_src_e au1_src;
        au2_op_e  au2_op;
        r1_sel_e  r1_sel;
        r2_sel_e  r2_sel;
        logic     r3_en;
    } sra_ctrl_t;

endpackage

// File: rtl/sra_au1.sv
// Four-function arithmetic unit: saturating absolute value of opa,
// unsigned min, add and subtract.
// Assumes opa/opb are non-negative for min/add/sub and that the schedule
// never asks for a sum or difference that leaves the W-bit unsigned range.
module sra_au1
    import sra_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  au1_op_e      op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] res
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

    // Select the result of the requested operation.
    always_comb begin
        unique case (op)
            AU1_ABS: begin
                if (opa == MOST_NEG)  res = MOST_POS;
                else if (opa[W-1])    res = -opa;
                else                  res = opa;
            end
            AU1_MIN: res = (opa < opb) ? opa : opb;
            AU1_ADD: res = opa + opb;
            default: res = opa - opb;
        endcase
    end

    // R5: a saturated absolute value never has its sign bit set.
    a_r5_abs_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        (op == AU1_ABS) |-> !res[W-1]);

    // R4: the minimum never exceeds either operand.
    a_r4_min_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (op == AU1_MIN) |-> (res <= opa && res <= opb));

    // R4: a sum of non-negative operands does not wrap.
    a_r4_add_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (op == AU1_ADD) |-> (res >= opa));

endmodule

// File: rtl/sra_au2.sv
// Two-function arithmetic unit: saturating absolute value of opa and
// unsigned max of opa and opb.
// Assumes opa/opb are non-negative whenever max is requested.
module sra_au2
    import sra_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  au2_op_e      op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] res
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

    // Select absolute value or maximum.
    always_comb begin
        if (op == AU2_ABS) begin
            if (opa == MOST_NEG)  res = MOST_POS;
            else if (opa[W-1])    res = -opa;
            else                  res = opa;
        end else begin
            res = (opa > opb) ? opa : opb;
        end
    end

    // R5: a saturated absolute value never has its sign bit set.
    a_r5_abs2_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        (op == AU2_ABS) |-> !res[W-1]);

    // R9: the maximum is at least each operand.
    a_r9_max_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (op == AU2_MAX) |-> (res >= opa && res >= opb));

endmodule

// File: rtl/sra_rshift.sv
// Fixed logical right shifter by SH bits; truncates toward zero.
// Assumes the operand is a non-negative magnitude.
module sra_rshift #(
    parameter int W  = 16,
    parameter int SH = 1
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    // Constant shift: pure wiring.
    always_comb dout = din >> SH;
endmodule

// File: rtl/sra_ctrl.sv
// Schedule controller: steps through the seven-state schedule after an
// accepted start and issues one control word per state.
// Assumes start is only meaningful in idle; it is ignored elsewhere.
module sra_ctrl
    import sra_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output sra_state_e state,
    output sra_ctrl_t  ctrl,
    output logic       done
);
    sra_state_e st_q, st_d;

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next-state function: a fixed walk once started.
    always_comb begin
        unique case (st_q)
            ST_IDLE:  st_d = start ? ST_ABS : ST_IDLE;
            ST_ABS:   st_d = ST_ORDER;
            ST_ORDER: st_d = ST_SCALE;
            ST_SCALE: st_d = ST_TRIM;
            ST_TRIM:  st_d = ST_SUM;
            ST_SUM:   st_d = ST_PICK;
            ST_PICK:  st_d = ST_DONE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // Control word decode: one operation per unit per state.
    always_comb begin
        ctrl = '{au1_op: AU1_ABS, au1_src: SRC_R2, au2_op: AU2_ABS,
                 r1_sel: R1_KEEP, r2_sel: R2_KEEP, r3_en: 1'b0};
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    ctrl.r1_sel = R1_INPUT;
                    ctrl.r2_sel = R2_INPUT;
                end
            end
            ST_ABS: begin
                ctrl.au2_op  = AU2_ABS;
                ctrl.au1_op  = AU1_ABS;
                ctrl.au1_src = SRC_R2;
                ctrl.r1_sel  = R1_FROM_AU2;
                ctrl.r2_sel  = R2_FROM_AU1;
            end
            ST_ORDER: begin
                ctrl.au2_op  = AU2_MAX;
                ctrl.au1_op  = AU1_MIN;
                ctrl.au1_src = SRC_R1;
                ctrl.r1_sel  = R1_FROM_AU2;
                ctrl.r2_sel  = R2_FROM_AU1;
            end
            ST_SCALE: begin
                ctrl.r3_en  = 1'b1;
                ctrl.r2_sel = R2_FROM_SH;
            end
            ST_TRIM: begin
                ctrl.au1_op  = AU1_SUB;
                ctrl.au1_src = SRC_R1;
                ctrl.r2_sel  = R2_FROM_AU1;
            end
            ST_SUM: begin
                ctrl.au1_op  = AU1_ADD;
                ctrl.au1_src = SRC_R3;
                ctrl.r2_sel  = R2_FROM_AU1;
            end
            ST_PICK: begin
                ctrl.au2_op = AU2_MAX;
                ctrl.r1_sel = R1_FROM_AU2;
            end
            default: ;
        endcase
    end

    assign state = st_q;
    assign done  = (st_q == ST_DONE);

    // R2: the last schedule step is always followed by the done cycle.
    a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PICK) |=> done);

    // R3: done lasts exactly one cycle.
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: a busy controller never restarts the schedule.
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |=> (st_q != ST_ABS));

endmodule

// File: rtl/sra_magnitude.sv
// Top level: three shared working registers, two merged arithmetic units
// and two fixed shifters, sequenced by sra_ctrl.
// Register use over a run:
//   R1: a, |a|, x, result
//   R2: b, |b|, y, x>>3, x-x>>3, sum
//   R3: y>>1
// Assumes inputs are two's complement; mag is R1 and is meaningful when
// done is high and until the next accepted start.
module sra_magnitude
    import sra_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic [W-1:0] mag,
    output logic         done
);
    localparam int SH_SMALL = 1;
    localparam int SH_LARGE = 3;

    sra_state_e   state;
    sra_ctrl_t    ctrl;
    logic [W-1:0] r1_q, r2_q, r3_q;
    logic [W-1:0] au1_a, au1_res, au2_res;
    logic [W-1:0] sh_res [2];
    logic [W-1:0] sh_src [2];

    sra_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .state (state),
        .ctrl  (ctrl),
        .done  (done)
    );

    // First-operand mux of the four-function unit.
    always_comb begin
        unique case (ctrl.au1_src)
            SRC_R1:  au1_a = r1_q;
            SRC_R3:  au1_a = r3_q;
            default: au1_a = r2_q;
        endcase
    end

    sra_au1 #(.W(W)) u_au1 (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (ctrl.au1_op),
        .opa   (au1_a),
        .opb   (r2_q),
        .res   (au1_res)
    );

    sra_au2 #(.W(W)) u_au2 (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (ctrl.au2_op),
        .opa   (r1_q),
        .opb   (r2_q),
        .res   (au2_res)
    );

    // Shifter 0 halves y (from R2); shifter 1 divides x (from R1) by eight.
    assign sh_src[0] = r2_q;
    assign sh_src[1] = r1_q;

    for (genvar g = 0; g < 2; g++) begin : g_shift
        sra_rshift #(
            .W  (W),
            .SH ((g == 0) ? SH_SMALL : SH_LARGE)
        ) u_sh (
            .din  (sh_src[g]),
            .dout (sh_res[g])
        );
    end

    // R1 update: input load or result of the two-function unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r1_q <= '0;
        end else begin
            unique case (ctrl.r1_sel)
                R1_INPUT:    r1_q <= in_a;
                R1_FROM_AU2: r1_q <= au2_res;
                default:     r1_q <= r1_q;
            endcase
        end
    end

    // R2 update: input load, four-function result or the divide-by-eight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r2_q <= '0;
        end else begin
            unique case (ctrl.r2_sel)
                R2_INPUT:    r2_q <= in_b;
                R2_FROM_AU1: r2_q <= au1_res;
                R2_FROM_SH:  r2_q <= sh_res[1];
                default:     r2_q <= r2_q;
            endcase
        end
    end

    // R3 update: captures the halved minimum.
    always_ff @(posedge clk) begin
        if (!rst_n)          r3_q <= '0;
        else if (ctrl.r3_en) r3_q <= sh_res[0];
    end

    assign mag = r1_q;

    // R7: an idle block without a start keeps its result.
    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> $stable(mag));

    // R9: the final max step never lowers the result below x held in R1.
    a_r9_result_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PICK) |=> (mag >= $past(r1_q)));

endmodule

// File: tb/sra_magnitude_bench.sv
// Bench: behavioural reference model compared with the outputs every clock,
// plus directed checks of the corner cases.
module sra_magnitude_bench;
    localparam int W      = 16;
    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic [W-1:0] mag;
    logic         done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference model state.
    int pend    = 0;
    int exp_res = 0;
    bit cmp_on  = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    sra_magnitude #(.W(W)) u_sra_magnitude (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .in_a  (in_a),
        .in_b  (in_b),
        .mag   (mag),
        .done  (done)
    );

    function automatic int sat_abs(input logic [W-1:0] v);
        int s;
        s = $signed(v);
        if (s == -(1 << (W-1))) return (1 << (W-1)) - 1;
        return (s < 0) ? -s : s;
    endfunction

    function automatic int model(input logic [W-1:0] a, input logic [W-1:0] b);
        int p, q, x, y, t;
        p = sat_abs(a);
        q = sat_abs(b);
        x = (p > q) ? p : q;
        y = (p > q) ? q : p;
        t = x - (x >> 3) + (y >> 1);
        return (t > x) ? t : x;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // Cycle model: accepts start only when idle; done after seven edges.
    always @(posedge clk) begin
        if (!rst_n) begin
            pend = 0;
            exp_res = 0;
        end else if (pend > 0) begin
            pend = pend - 1;
        end else if (start) begin
            pend = 7;
            exp_res = model(in_a, in_b);
        end
    end

    // Per-clock comparison of done and of the held result (R2 R3 R4 R6 R7).
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            check(done == (pend == 1), "R2 R3 R6 done", int'(done), int'(pend == 1));
            if (pend <= 1)
                check(int'(mag) == exp_res, "R4 R7 mag", int'(mag), exp_res);
        end
    end

    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, output int res);
        @(negedge clk);
        in_a = a;
        in_b = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        in_a = '0;
        in_b = '0;
        res = -1;
        for (int i = 0; i < 12; i++) begin
            if (done) begin
                res = int'(mag);
                break;
            end
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int r, r2;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(mag == '0, "R1 mag", int'(mag), 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);

        run(16'd3, 16'd4, r);
        check(r == model(16'd3, 16'd4), "R4 3,4", r, model(16'd3, 16'd4));
        run(16'hFFFD, 16'd4, r);
        check(r == model(16'hFFFD, 16'd4), "R4 neg", r, model(16'hFFFD, 16'd4));
        run(16'd0, 16'd0, r);
        check(r == 0, "R4 zero", r, 0);
        run(16'h8000, 16'd0, r);
        check(r == 32767, "R5 most negative", r, 32767);
        run(16'h8000, 16'h8000, r);
        check(r == model(16'h8000, 16'h8000), "R5 both", r, model(16'h8000, 16'h8000));
        run(16'h7FFF, 16'h8001, r);
        check(r == model(16'h7FFF, 16'h8001), "R4 full scale", r, model(16'h7FFF, 16'h8001));
        run(16'd800, 16'd1, r);
        check(r == 800, "R9 max term wins", r, 800);
        run(16'd1234, 16'hF9C0, r);
        run(16'hF9C0, 16'd1234, r2);
        check(r == r2, "R8 swap", r2, r);
        check(r >= 1600, "R9 floor", r, 1600);

        // R6: start held high across several runs; the model checks each pulse.
        @(negedge clk);
        in_a = 16'd500;
        in_b = 16'hFF00;
        start = 1'b1;
        repeat (26) @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);

        // R7: result held over an idle stretch.
        r = int'(mag);
        repeat (5) @(negedge clk);
        check(int'(mag) == r, "R7 hold", int'(mag), r);

        // R1: reset after activity clears outputs.
        rst_n = 1'b0;
        cmp_on = 1'b0;
        @(negedge clk);
        check(mag == '0 && !done, "R1 re-reset", int'(mag), 0);
        finish_run();
    end
endmodule